// File: doc/BRIEF.md
# S/PDIF Transmit Formatter

This block turns a stream of parallel audio samples into a biphase-mark coded serial line in the IEC-60958 consumer style. Samples are taken alternately for the left and the right channel. Each one is placed in a 32-bit subframe together with a validity bit, a user-data bit and a channel-status bit, followed by an even-parity bit. The status and user bits come from four 192-bit register files, one status file and one user file for each channel. Each channel also has its own validity flag.

The line runs at one cell per clock, so a subframe lasts 64 clocks and a full 192-frame block lasts 384 subframes. A single-entry holding register sits between the sample handshake and the serializer. A slot that starts with no sample waiting is still sent, but with a zero payload. When the mode is disabled, the line rests low. Enabling it again restarts the stream at frame 0 on the left channel.

Top module: `spdif_tx_formatter`

## Requirements
- R1: After reset, `lineOut` and `slotStart` are low, and `sampleReady` is low while `enable` is low.
- R2: While `enable` is low, `lineOut` stays low, `slotStart` stays low and `sampleReady` is low. Clearing `enable` discards any held sample. The next enable starts again at frame 0 on the left channel, with a B preamble.
- R3: One sample is held at most. `sampleReady` is high only when enabled and the hold is empty. The first subframe after enable starts only once a sample has been accepted, and that subframe is left, frame 0.
- R4: A subframe lasts exactly 64 clocks, with two line cells per bit. Bits 0–3 are the preamble. Bits 4–27 carry the low 24 bits of `sampleData`, least significant bit first. Bits above bit 23 of `sampleData` are ignored.
- R5: Subframes alternate left, right, left, and so on. Samples are used in the order they were accepted. The frame index counts 0 to 191 and then wraps to 0.
- R6: Preamble cell patterns are given first cell first, for a line that was low before the preamble; they are inverted when the line was high. Left subframe of frame 0 uses 11101000. Other left subframes use 11100010. Right subframes use 11100100.
- R7: From bit 4 on, the line changes level at every bit boundary, and also at mid-bit when the bit is 1. The level carries over from one subframe into the next.
- R8: Bit 28 is the channel's validity flag. Bit 29 is bit k of that channel's user file and bit 30 is bit k of that channel's status file, where k is the frame index.
- R9: Bit 31 makes the number of ones in bits 4 to 31 even.
- R10: `cfgAddr[5:3]` selects the target: 0 is the left status file, 1 the right status file, 2 the left user file, 3 the right user file, and 4 the validity flags. For targets 0 to 3, `cfgAddr[2:0]` is the word w (0 to 5), and data bit j writes frame 32w+j. For target 4, `cfgWrData[0]` is the left flag and `cfgWrData[1]` the right flag, and the word index is ignored. Word indices 6 and 7, and targets 5 to 7, change nothing.
- R11: If no sample is held when a subframe is loaded, that subframe carries a zero payload. It keeps its normal preamble and its V, U, C and P bits.
- R12: `slotStart` is high for exactly one clock, in the clock where `lineOut` shows the first preamble cell of a subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line cell per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Formatter mode enable |
| sampleData | input | 32 | Audio sample; low 24 bits used |
| sampleValid | input | 1 | Sample offered |
| sampleReady | output | 1 | Hold register can take a sample |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Configuration target and word index |
| cfgWrData | input | 32 | Configuration write data |
| lineOut | output | 1 | Biphase-mark coded serial line |
| slotStart | output | 1 | Marks the first cell of each subframe |

## Verification
The inline assertions check, on every cycle, several properties that hold at all times: a level change at every data bit boundary, a change on the first preamble cell, a quiet line while disabled, at most one sample held, a frame counter that wraps at the end of the block, and validity flags that move only on a write to them. Other behaviour can only be shown by the scoreboard scenarios, which decode the line from the outside: which preamble each subframe gets, the payload content and its order, status and user bits picked by frame index across all six words, parity, zero payload in underrun slots, ignored configuration writes, and the restart at frame 0 after a held sample has been dropped.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

  localparam int SUB_BITS    = 32;
  localparam int PRE_BITS    = 4;
  localparam int PAYLOAD_W   = SUB_BITS - 8;
  localparam int CELLS       = 2 * SUB_BITS;
  localparam int CELL_W      = $clog2(CELLS);
  localparam int FRAME_IDX_W = 8;
  localparam int VAL_POS     = PRE_BITS + PAYLOAD_W;
  localparam int USR_POS     = VAL_POS + 1;
  localparam int STS_POS     = VAL_POS + 2;
  localparam int PAR_POS     = VAL_POS + 3;

  typedef enum logic [1:0] {
    PRE_B = 2'd0,
    PRE_M = 2'd1,
    PRE_W = 2'd2
  } preKind_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic                   load;
    logic                   loadRight;
    logic [FRAME_IDX_W-1:0] loadFrame;
    preKind_e               loadPre;
    logic                   emit;
    logic [CELL_W-1:0]      cellIdx;
  } ctrlStrb_t;

  // Preamble expressed as per-cell toggles of the line level
  function automatic logic preToggle(preKind_e kind, logic [2:0] idx);
    logic [7:0] t;
    case (kind)
      PRE_B:   t = 8'b0011_1001;
      PRE_M:   t = 8'b1100_1001;
      default: t = 8'b0110_1001;
    endcase
    return t[idx];
  endfunction

endpackage

// File: rtl/spdif_tx_cfg.sv
module spdif_tx_cfg
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int CFG_W        = 32,
  localparam int WORDS       = BLOCK_FRAMES / CFG_W,
  localparam int WORD_AW     = $clog2(WORDS),
  localparam int ADDR_W      = 3 + WORD_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfgWrEn,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [CFG_W-1:0]        cfgWrData,
  output logic [BLOCK_FRAMES-1:0] statFile [2],
  output logic [BLOCK_FRAMES-1:0] userFile [2],
  output logic [1:0]              validBits
);

  localparam logic [2:0] FILE_STAT_L = 3'd0;
  localparam logic [2:0] FILE_USER_L = 3'd2;
  localparam logic [2:0] FILE_VALID  = 3'd4;

  logic [2:0]         fileSel;
  logic [WORD_AW-1:0] wordSel;

  assign fileSel = cfgAddr[ADDR_W-1 -: 3];
  assign wordSel = cfgAddr[WORD_AW-1:0];

  genvar s;
  for (s = 0; s < 2; s++) begin : g_side
    logic [BLOCK_FRAMES-1:0] statQ;
    logic [BLOCK_FRAMES-1:0] userQ;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        statQ <= '0;
        userQ <= '0;
      end else if (cfgWrEn) begin
        for (int w = 0; w < WORDS; w++) begin
          if (wordSel == WORD_AW'(w)) begin
            if (fileSel == FILE_STAT_L + 3'(s)) statQ[w*CFG_W +: CFG_W] <= cfgWrData;
            if (fileSel == FILE_USER_L + 3'(s)) userQ[w*CFG_W +: CFG_W] <= cfgWrData;
          end
        end
      end
    end

    assign statFile[s] = statQ;
    assign userFile[s] = userQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validBits <= '0;
    else if (cfgWrEn && fileSel == FILE_VALID) validBits <= cfgWrData[1:0];
  end

  // R10: validity flags only move on a write aimed at them
  a_r10_valid_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfgWrEn && fileSel == FILE_VALID) |=> $stable(validBits));

endmodule

// File: rtl/spdif_tx_ctrl.sv
module spdif_tx_ctrl
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      holdFull,
  output ctrlStrb_t strb
);

  localparam logic [FRAME_IDX_W-1:0] LAST_FRAME = FRAME_IDX_W'(BLOCK_FRAMES - 1);
  localparam logic [CELL_W-1:0]      LAST_CELL  = CELL_W'(CELLS - 1);

  logic                   running;
  logic [CELL_W-1:0]      cellCnt;
  logic                   isRight;
  logic [FRAME_IDX_W-1:0] frameCnt;
  logic                   startNow;
  logic                   lastCell;
  logic                   nextRight;
  logic [FRAME_IDX_W-1:0] nextFrame;

  assign startNow = enable && !running && holdFull;
  assign lastCell = running && (cellCnt == LAST_CELL);

  always_comb begin
    if (startNow) begin
      nextRight = 1'b0;
      nextFrame = '0;
    end else begin
      nextRight = !isRight;
      if (isRight) nextFrame = (frameCnt == LAST_FRAME) ? '0 : frameCnt + 1'b1;
      else         nextFrame = frameCnt;
    end
  end

  always_comb begin
    strb.load      = startNow || (enable && lastCell);
    strb.loadRight = nextRight;
    strb.loadFrame = nextFrame;
    if (nextRight)              strb.loadPre = PRE_W;
    else if (nextFrame == '0)   strb.loadPre = PRE_B;
    else                        strb.loadPre = PRE_M;
    strb.emit      = running && enable;
    strb.cellIdx   = cellCnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cellCnt  <= '0;
      isRight  <= 1'b0;
      frameCnt <= '0;
    end else if (!enable) begin
      running  <= 1'b0;
      cellCnt  <= '0;
      isRight  <= 1'b0;
      frameCnt <= '0;
    end else if (startNow) begin
      running  <= 1'b1;
      cellCnt  <= '0;
      isRight  <= 1'b0;
      frameCnt <= '0;
    end else if (running) begin
      cellCnt <= lastCell ? '0 : cellCnt + 1'b1;
      if (lastCell) begin
        isRight  <= nextRight;
        frameCnt <= nextFrame;
      end
    end
  end

  // R5: the last right subframe of a block is followed by left, frame 0
  a_r5_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && lastCell && isRight && frameCnt == LAST_FRAME)
      |=> (!enable || (frameCnt == '0 && !isRight)));

endmodule

// File: rtl/spdif_tx_dp.sv
module spdif_tx_dp
  import spdif_tx_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [DATA_W-1:0]       sampleData,
  input  logic                    sampleValid,
  output logic                    sampleReady,
  output logic                    holdFull,
  input  ctrlStrb_t               strb,
  input  logic [BLOCK_FRAMES-1:0] statFile [2],
  input  logic [BLOCK_FRAMES-1:0] userFile [2],
  input  logic [1:0]              validBits,
  output logic                    lineOut,
  output logic                    slotStart
);

  localparam logic [DATA_W-1:0] PAY_MASK = DATA_W'((64'd1 << PAYLOAD_W) - 1);

  logic [DATA_W-1:0]   holdData;
  logic                accept;
  logic [SUB_BITS-1:0] nextWord;
  logic [SUB_BITS-1:0] slotWord;
  preKind_e            slotPre;
  logic [CELL_W-2:0]   bitIdx;
  logic                toggle;
  logic                level;
  logic                startQ;

  assign sampleReady = enable && !holdFull;
  assign accept      = sampleValid && sampleReady;

  // Single-entry hold between handshake and serializer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdFull <= 1'b0;
      holdData <= '0;
    end else if (!enable) begin
      holdFull <= 1'b0;
    end else if (accept) begin
      holdFull <= 1'b1;
      holdData <= sampleData & PAY_MASK;
    end else if (strb.load) begin
      holdFull <= 1'b0;
    end
  end

  // Subframe assembly: payload rotated past the preamble, aux bits, parity
  always_comb begin
    nextWord = holdFull ? SUB_BITS'({holdData, {PRE_BITS{1'b0}}}) : '0;
    nextWord[VAL_POS] = validBits[strb.loadRight];
    nextWord[USR_POS] = userFile[strb.loadRight][strb.loadFrame];
    nextWord[STS_POS] = statFile[strb.loadRight][strb.loadFrame];
    nextWord[PAR_POS] = ^nextWord[STS_POS:PRE_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotWord <= '0;
      slotPre  <= PRE_B;
    end else if (strb.load) begin
      slotWord <= nextWord;
      slotPre  <= strb.loadPre;
    end
  end

  // Biphase-mark line coding as per-cell toggles
  assign bitIdx = strb.cellIdx[CELL_W-1:1];

  always_comb begin
    if (bitIdx < (CELL_W-1)'(PRE_BITS)) toggle = preToggle(slotPre, strb.cellIdx[2:0]);
    else if (strb.cellIdx[0])            toggle = slotWord[bitIdx];
    else                                 toggle = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= 1'b0;
      startQ <= 1'b0;
    end else if (!enable) begin
      level  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      startQ <= strb.emit && (strb.cellIdx == '0);
      if (strb.emit) level <= level ^ toggle;
    end
  end

  assign lineOut   = level;
  assign slotStart = startQ;

  // R3: an accepted sample fills the hold, so ready drops next cycle
  a_r3_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && sampleReady) |=> !sampleReady);

  // R2: a disabled formatter leaves the line quiet
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!lineOut && !slotStart));

  // R7: every data-bit boundary flips the line
  a_r7_bit_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.emit && strb.cellIdx >= CELL_W'(2*PRE_BITS) && !strb.cellIdx[0])
      |=> (lineOut != $past(lineOut)));

  // R12: the first preamble cell always flips the line
  a_r12_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    slotStart |-> (lineOut != $past(lineOut)));

endmodule

// File: rtl/spdif_tx_formatter.sv
module spdif_tx_formatter
  import spdif_tx_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int BLOCK_FRAMES = 192,
  parameter int CFG_W        = 32,
  localparam int CFG_AW      = 3 + $clog2(BLOCK_FRAMES / CFG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              sampleValid,
  output logic              sampleReady,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic              lineOut,
  output logic              slotStart
);

  ctrlStrb_t               strb;
  logic                    holdFull;
  logic [BLOCK_FRAMES-1:0] statFile [2];
  logic [BLOCK_FRAMES-1:0] userFile [2];
  logic [1:0]              validBits;

  spdif_tx_cfg #(.BLOCK_FRAMES(BLOCK_FRAMES), .CFG_W(CFG_W)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .statFile  (statFile),
    .userFile  (userFile),
    .validBits (validBits)
  );

  spdif_tx_ctrl #(.BLOCK_FRAMES(BLOCK_FRAMES)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .holdFull (holdFull),
    .strb     (strb)
  );

  spdif_tx_dp #(.DATA_W(DATA_W), .BLOCK_FRAMES(BLOCK_FRAMES)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .sampleReady (sampleReady),
    .holdFull    (holdFull),
    .strb        (strb),
    .statFile    (statFile),
    .userFile    (userFile),
    .validBits   (validBits),
    .lineOut     (lineOut),
    .slotStart   (slotStart)
  );

endmodule

// File: tb/spdif_tx_formatter_tb_top.sv
`timescale 1ns/1ps
module spdif_tx_formatter_tb_top;

  localparam int FR = 192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] sampleData = '0;
  logic        sampleValid = 1'b0;
  logic        sampleReady;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        lineOut;
  logic        slotStart;

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  int underruns = 0;
  bit finished = 0;

  typedef struct {
    logic [23:0] pay;
    int          stamp;
  } item_t;
  item_t expQ[$];

  logic [FR-1:0] mStat [2];
  logic [FR-1:0] mUser [2];
  logic          mValid [2];

  spdif_tx_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .sampleData(sampleData), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .lineOut(lineOut), .slotStart(slotStart)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // R10 address map mirrored in the bench model
  task automatic cfgWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a[5:3] == 3'd4) begin
      mValid[0] = d[0];
      mValid[1] = d[1];
    end else if (a[2:0] < 3'd6) begin
      case (a[5:3])
        3'd0: mStat[0][a[2:0]*32 +: 32] = d;
        3'd1: mStat[1][a[2:0]*32 +: 32] = d;
        3'd2: mUser[0][a[2:0]*32 +: 32] = d;
        3'd3: mUser[1][a[2:0]*32 +: 32] = d;
        default: ;
      endcase
    end
  endtask

  task automatic loadConfig(logic [31:0] salt, logic [1:0] vflags);
    for (int w = 0; w < 6; w++) begin
      cfgWrite({3'd0, 3'(w)}, 32'h9E37_79B9 * (w + 1) ^ salt);
      cfgWrite({3'd1, 3'(w)}, 32'h85EB_CA6B * (w + 3) ^ salt);
      cfgWrite({3'd2, 3'(w)}, (32'h7F4A_7C15 ^ (32'h0101_0101 << w)) + salt);
      cfgWrite({3'd3, 3'(w)}, 32'hC2B2_AE35 * (w + 7) - salt);
    end
    cfgWrite({3'd4, 3'd0}, {30'd0, vflags});
  endtask

  function automatic logic [31:0] mkSample(int k);
    return (32'h0013_579B * k + 32'h0002_4681) | 32'h8100_0000;
  endfunction

  // Driver: pushes each accepted sample with its acceptance stamp
  task automatic drive(int n, int seed, int gapAt, int gapLen);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (i == gapAt) begin
        sampleValid = 1'b0;
        repeat (gapLen) @(negedge clk);
      end
      sampleValid = 1'b1;
      sampleData  = mkSample(seed + i);
      while (!sampleReady) @(negedge clk);
      expQ.push_back('{sampleData[23:0], cyc});
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  // Monitor: decodes the line and compares each subframe against the model
  task automatic monitor(int nSlots, string tag);
    logic        c [64];
    logic        prevLvl;
    int          prevS;
    int          s;
    int          side;
    int          frame;
    logic [7:0]  pat;
    logic [7:0]  gotPre;
    logic [31:0] word;
    logic [23:0] expPay;
    bit          edgesOk;
    bit          stray;
    prevLvl = 1'b0;
    prevS   = -1;
    for (int slot = 0; slot < nSlots; slot++) begin
      @(negedge clk);
      while (!slotStart) @(negedge clk);
      s = cyc;
      c[0] = lineOut;
      stray = 1'b0;
      for (int k = 1; k < 64; k++) begin
        @(negedge clk);
        c[k] = lineOut;
        if (slotStart) stray = 1'b1;
      end
      side  = slot % 2;
      frame = (slot / 2) % FR;
      if (side == 1)      pat = 8'b1110_0100;
      else if (frame == 0) pat = 8'b1110_1000;
      else                pat = 8'b1110_0010;
      pat = pat ^ {8{prevLvl}};
      for (int k = 0; k < 8; k++) gotPre[7-k] = c[k];
      chk(gotPre == pat, "R6", $sformatf("%s preamble slot %0d", tag, slot), gotPre, pat);
      edgesOk = 1'b1;
      word = '0;
      for (int b = 4; b < 32; b++) begin
        if (c[2*b] == c[2*b-1]) edgesOk = 1'b0;
        word[b] = c[2*b] ^ c[2*b+1];
      end
      chk(edgesOk, "R7", $sformatf("%s bit boundaries slot %0d", tag, slot), edgesOk, 1);
      chk(!stray, "R12", $sformatf("%s single start pulse slot %0d", tag, slot), stray, 0);
      if (prevS >= 0)
        chk(s - prevS == 64, "R4", $sformatf("%s subframe length slot %0d", tag, slot), s - prevS, 64);
      if (expQ.size() > 0 && expQ[0].stamp <= s - 3) begin
        expPay = expQ[0].pay;
        void'(expQ.pop_front());
        chk(word[27:4] == expPay, "R5", $sformatf("%s payload slot %0d", tag, slot), word[27:4], expPay);
      end else begin
        expPay = '0;
        underruns++;
        chk(word[27:4] == expPay, "R11", $sformatf("%s underrun payload slot %0d", tag, slot), word[27:4], expPay);
      end
      chk(word[28] == mValid[side], "R8", $sformatf("%s validity slot %0d", tag, slot), word[28], mValid[side]);
      chk(word[29] == mUser[side][frame], "R8", $sformatf("%s user bit slot %0d", tag, slot), word[29], mUser[side][frame]);
      chk(word[30] == mStat[side][frame], "R8", $sformatf("%s status bit slot %0d", tag, slot), word[30], mStat[side][frame]);
      chk((^word[31:4]) == 1'b0, "R9", $sformatf("%s parity slot %0d", tag, slot), word[31], ^word[30:4]);
      prevLvl = c[63];
      prevS = s;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    for (int sd = 0; sd < 2; sd++) begin
      mStat[sd] = '0; mUser[sd] = '0; mValid[sd] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(lineOut == 1'b0, "R1", "reset lineOut", lineOut, 0);
    chk(slotStart == 1'b0, "R1", "reset slotStart", slotStart, 0);
    chk(sampleReady == 1'b0, "R1", "reset ready while disabled", sampleReady, 0);
    rst_n = 1'b1;

    // Phase 1: full block plus wrap, with an underrun gap; upper data bits set (R4)
    loadConfig(32'h0000_0000, 2'b10);
    @(negedge clk);
    chk(lineOut == 1'b0 && slotStart == 1'b0, "R3", "idle before enable", lineOut, 0);
    enable = 1'b1;
    repeat (20) @(negedge clk);
    chk(slotStart == 1'b0 && lineOut == 1'b0, "R3", "no subframe before first sample", lineOut, 0);
    fork
      drive(400, 0, 200, 300);
      monitor(392, "ph1");
    join
    chk(underruns > 0, "R11", "underrun slots seen in gap", underruns, 1);

    // R2: a sample held at disable is dropped
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = 32'hFFAB_CDEF;
    while (!sampleReady) @(negedge clk);
    @(negedge clk);
    sampleValid = 1'b0;
    enable = 1'b0;
    expQ.delete();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(lineOut == 1'b0 && slotStart == 1'b0, "R2", "line quiet while disabled", lineOut, 0);
      chk(sampleReady == 1'b0, "R2", "ready low while disabled", sampleReady, 0);
    end

    // Phase 2: new config, ignored writes (R10), restart at frame 0
    loadConfig(32'h5A5A_0F0F, 2'b01);
    cfgWrite({3'd0, 3'd6}, 32'hFFFF_FFFF);
    cfgWrite({3'd2, 3'd7}, 32'hFFFF_FFFF);
    cfgWrite({3'd5, 3'd0}, 32'hFFFF_FFFF);
    cfgWrite({3'd7, 3'd1}, 32'hFFFF_FFFF);
    enable = 1'b1;
    fork
      drive(30, 1000, -1, 0);
      monitor(24, "ph2");
    join

    finished = 1;
    summary();
    $finish;
  end

endmodule